// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through data cache (or the victim path of a write-back cache) and the next memory level. Stores are absorbed into a small queue of address/data entries so the processor keeps running, and the queue empties into the memory write channel one entry at a time, oldest first. A cache read miss enters through a separate request channel and is answered on a response channel.

Read misses are handled in one of two ways, picked per request by a mode input. In the careful mode the read waits until every queued write has reached memory, and only then goes out. In the bypass mode the miss address is compared with every queued entry. If no entry matches, the read is sent to memory at once, ahead of the older writes. If an entry matches, the newest matching entry answers the read directly and memory is not touched. While a read is out at memory the queue stops draining, so the two kinds of request never share the memory side at the same time.

Top module: `wr_bypass_buf`

## Requirements
- R1: `wr_ready_o` is high exactly when fewer than DEPTH entries are held and no careful-mode read is waiting for the queue to empty; a write is taken on a cycle where `wr_valid_i` and `wr_ready_o` are both high.
- R2: Queued writes appear on the memory write channel in the order they were taken, with their exact address and data; `mem_wr_valid_o` is high whenever the queue is non-empty and no read occupies the memory side; one entry leaves per `mem_wr_valid_o`/`mem_wr_ready_i` handshake.
- R3: With DEPTH entries held, `wr_ready_o` is low and an offered write is not stored.
- R4: In bypass mode a read with no matching entry raises `mem_rd_valid_o` with its address on the cycle after acceptance, even when older writes are still queued; valid and address hold until `mem_rd_ready_i`.
- R5: In bypass mode a read that matches a queued address gets `rd_resp_valid_o` on the cycle after acceptance, with the data of the newest matching entry, and no memory read is issued.
- R6: A write and a read taken in the same cycle are ordered write first: the read sees the new write, and in bypass mode a matching same-cycle write supplies the response.
- R7: From the cycle `mem_rd_valid_o` rises until the cycle after `mem_rd_resp_valid_i`, `mem_wr_valid_o` stays low.
- R8: In careful mode (`fast_mode_i` = 0) a read always goes to memory, `mem_rd_valid_o` rises only after the queue is empty, and `wr_ready_o` is low from acceptance until then; the returned data includes every earlier write.
- R9: `fast_mode_i` is sampled only at read acceptance; later changes do not alter how that read is handled.
- R10: One read is handled at a time: `rd_ready_o` is low from acceptance until the response; a memory answer on `mem_rd_resp_valid_i` produces `rd_resp_valid_o` with that data one cycle later.
- R11: After reset the queue is empty, `wr_ready_o` and `rd_ready_o` are high, and `mem_wr_valid_o`, `mem_rd_valid_o` and `rd_resp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_mode_i | input | 1 | 1: bypass mode with address compare, 0: careful mode that drains first |
| wr_valid_i | input | 1 | Write offered by the cache |
| wr_ready_o | output | 1 | Buffer can take a write |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_valid_i | input | 1 | Read miss offered |
| rd_ready_o | output | 1 | Read miss can be taken |
| rd_addr_i | input | AW | Read miss address |
| rd_resp_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rd_resp_data_o | output | DW | Read data |
| mem_wr_valid_o | output | 1 | Oldest entry offered to memory |
| mem_wr_ready_i | input | 1 | Memory takes the write |
| mem_wr_addr_o | output | AW | Write address to memory |
| mem_wr_data_o | output | DW | Write data to memory |
| mem_rd_valid_o | output | 1 | Read request to memory |
| mem_rd_ready_i | input | 1 | Memory takes the read request |
| mem_rd_addr_o | output | AW | Read address to memory |
| mem_rd_resp_valid_i | input | 1 | Memory read data valid |
| mem_rd_resp_data_i | input | DW | Memory read data |

## Verification
Two events that can share a cycle are the acceptance of a write and the acceptance of a read miss, and also a read acceptance together with the oldest entry leaving for memory. The bench provokes both through directed steps that offer a write and a read to the same address together (with the memory write channel stalled, and with a match to an older entry as well), and through long random runs with dense traffic on a small address range. It judges them against a reference that applies same-cycle writes before the read and counts an entry leaving on the read's cycle as still present for the compare, then checks the returned data, the path taken, and the order of writes reaching memory.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE,
    RD_DRAIN,
    RD_ISSUE,
    RD_WAIT
  } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [AW-1:0]                  push_addr_i,
  input  logic [DW-1:0]                  push_data_i,
  input  logic                           pop_i,
  output logic [DEPTH-1:0][AW-1:0]       ent_addr_o,
  output logic [DEPTH-1:0][DW-1:0]       ent_data_o,
  output logic [DEPTH-1:0]               ent_vld_o,
  output logic [$clog2(DEPTH)-1:0]       head_o,
  output logic [$clog2(DEPTH):0]         count_o,
  output logic [AW-1:0]                  head_addr_o,
  output logic [DW-1:0]                  head_data_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W:0]   wr_ptr_q, rd_ptr_q;
  logic [PTR_W-1:0] wr_idx, rd_idx;

  assign wr_idx = wr_ptr_q[PTR_W-1:0];
  assign rd_idx = rd_ptr_q[PTR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        addr_q <= '0;
        data_q <= '0;
      end else if (push_i && wr_idx == PTR_W'(g)) begin
        vld_q  <= 1'b1;
        addr_q <= push_addr_i;
        data_q <= push_data_i;
      end else if (pop_i && rd_idx == PTR_W'(g)) begin
        vld_q  <= 1'b0;
      end
    end

    assign ent_vld_o[g]  = vld_q;
    assign ent_addr_o[g] = addr_q;
    assign ent_data_o[g] = data_q;
  end

  assign head_o      = rd_idx;
  assign count_o     = wr_ptr_q - rd_ptr_q;
  assign head_addr_o = ent_addr_o[rd_idx];
  assign head_data_o = ent_data_o[rd_idx];
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr_i,
  input  logic [DEPTH-1:0][DW-1:0] ent_data_i,
  input  logic [DEPTH-1:0]         ent_vld_i,
  input  logic [$clog2(DEPTH)-1:0] head_i,
  input  logic [AW-1:0]            q_addr_i,
  input  logic                     in_vld_i,
  input  logic [AW-1:0]            in_addr_i,
  input  logic [DW-1:0]            in_data_i,
  output logic                     hit_o,
  output logic [DW-1:0]            hit_data_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] slot_hit;
  logic [PTR_W-1:0] age_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign slot_hit[g] = ent_vld_i[g] && (ent_addr_i[g] == q_addr_i);
  end

  // scan from oldest to newest so the last hit wins; same-cycle write is newest
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    age_idx    = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      age_idx = head_i + PTR_W'(k);
      if (slot_hit[age_idx]) begin
        hit_o      = 1'b1;
        hit_data_o = ent_data_i[age_idx];
      end
    end
    if (in_vld_i && in_addr_i == q_addr_i) begin
      hit_o      = 1'b1;
      hit_data_o = in_data_i;
    end
  end
endmodule

// File: rtl/wbuf_rd_ctl.sv
module wbuf_rd_ctl
  import wbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_mode_i,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          hit_i,
  input  logic [DW-1:0] hit_data_i,
  input  logic          buf_empty_i,
  input  logic          mem_rd_ready_i,
  input  logic          mem_rd_resp_valid_i,
  input  logic [DW-1:0] mem_rd_resp_data_i,
  output logic          rd_ready_o,
  output logic          rd_resp_valid_o,
  output logic [DW-1:0] rd_resp_data_o,
  output logic          mem_rd_valid_o,
  output logic [AW-1:0] mem_rd_addr_o,
  output logic          drain_block_o,
  output logic          wr_pause_o,
  output logic          fast_q_o
);
  rd_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic          fast_q;
  logic          resp_v_q;
  logic [DW-1:0] resp_d_q;
  logic          accept;

  assign rd_ready_o = (state_q == RD_IDLE);
  assign accept     = rd_valid_i && rd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RD_IDLE;
      addr_q   <= '0;
      fast_q   <= 1'b0;
      resp_v_q <= 1'b0;
      resp_d_q <= '0;
    end else begin
      resp_v_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (accept) begin
          addr_q <= rd_addr_i;
          fast_q <= fast_mode_i;
          if (fast_mode_i && hit_i) begin
            resp_v_q <= 1'b1;
            resp_d_q <= hit_data_i;
          end else if (fast_mode_i) begin
            state_q <= RD_ISSUE;
          end else begin
            state_q <= RD_DRAIN;
          end
        end
        RD_DRAIN: if (buf_empty_i) state_q <= RD_ISSUE;
        RD_ISSUE: if (mem_rd_ready_i) state_q <= RD_WAIT;
        RD_WAIT: if (mem_rd_resp_valid_i) begin
          resp_v_q <= 1'b1;
          resp_d_q <= mem_rd_resp_data_i;
          state_q  <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_resp_valid_o = resp_v_q;
  assign rd_resp_data_o  = resp_d_q;
  assign mem_rd_valid_o  = (state_q == RD_ISSUE);
  assign mem_rd_addr_o   = addr_q;
  assign drain_block_o   = (state_q == RD_DRAIN);
  assign wr_pause_o      = (state_q == RD_ISSUE) || (state_q == RD_WAIT);
  assign fast_q_o        = fast_q;
endmodule

// File: rtl/wr_bypass_buf.sv
module wr_bypass_buf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fast_mode_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_valid_i,
  output logic          rd_ready_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_resp_valid_o,
  output logic [DW-1:0] rd_resp_data_o,
  output logic          mem_wr_valid_o,
  input  logic          mem_wr_ready_i,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  output logic          mem_rd_valid_o,
  input  logic          mem_rd_ready_i,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic          mem_rd_resp_valid_i,
  input  logic [DW-1:0] mem_rd_resp_data_i
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [DEPTH-1:0]         ent_vld;
  logic [PTR_W-1:0]         head;
  logic [CNT_W-1:0]         count;
  logic                     full, empty, push, pop;
  logic                     hit;
  logic [DW-1:0]            hit_data;
  logic                     drain_block, wr_pause, fast_q;

  assign full           = (count == CNT_W'(DEPTH));
  assign empty          = (count == '0);
  assign wr_ready_o     = !full && !drain_block;
  assign push           = wr_valid_i && wr_ready_o;
  assign mem_wr_valid_o = !empty && !wr_pause;
  assign pop            = mem_wr_valid_o && mem_wr_ready_i;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (wr_addr_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .ent_addr_o  (ent_addr),
    .ent_data_o  (ent_data),
    .ent_vld_o   (ent_vld),
    .head_o      (head),
    .count_o     (count),
    .head_addr_o (mem_wr_addr_o),
    .head_data_o (mem_wr_data_o)
  );

  wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .ent_addr_i (ent_addr),
    .ent_data_i (ent_data),
    .ent_vld_i  (ent_vld),
    .head_i     (head),
    .q_addr_i   (rd_addr_i),
    .in_vld_i   (push),
    .in_addr_i  (wr_addr_i),
    .in_data_i  (wr_data_i),
    .hit_o      (hit),
    .hit_data_o (hit_data)
  );

  wbuf_rd_ctl #(.AW(AW), .DW(DW)) u_rd_ctl (
    .clk_i               (clk_i),
    .rst_ni              (rst_ni),
    .fast_mode_i         (fast_mode_i),
    .rd_valid_i          (rd_valid_i),
    .rd_addr_i           (rd_addr_i),
    .hit_i               (hit),
    .hit_data_i          (hit_data),
    .buf_empty_i         (empty),
    .mem_rd_ready_i      (mem_rd_ready_i),
    .mem_rd_resp_valid_i (mem_rd_resp_valid_i),
    .mem_rd_resp_data_i  (mem_rd_resp_data_i),
    .rd_ready_o          (rd_ready_o),
    .rd_resp_valid_o     (rd_resp_valid_o),
    .rd_resp_data_o      (rd_resp_data_o),
    .mem_rd_valid_o      (mem_rd_valid_o),
    .mem_rd_addr_o       (mem_rd_addr_o),
    .drain_block_o       (drain_block),
    .wr_pause_o          (wr_pause),
    .fast_q_o            (fast_q)
  );
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     fast_mode_i,
  input logic                     wr_ready_o,
  input logic                     rd_valid_i,
  input logic                     rd_ready_o,
  input logic                     rd_resp_valid_o,
  input logic                     mem_wr_valid_o,
  input logic                     mem_rd_valid_o,
  input logic                     mem_rd_ready_i,
  input logic [AW-1:0]            mem_rd_addr_o,
  input logic                     mem_rd_resp_valid_i,
  input logic [$clog2(DEPTH):0]   count,
  input logic                     hit,
  input logic                     fast_q
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic rd_out_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rd_out_q <= 1'b0;
    else if (mem_rd_valid_o && mem_rd_ready_i)  rd_out_q <= 1'b1;
    else if (mem_rd_resp_valid_i)               rd_out_q <= 1'b0;
  end

  AST_FULL_BLOCKS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(DEPTH)) |-> !wr_ready_o); // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> !mem_wr_valid_o); // R2
  AST_PAUSE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_out_q |-> !mem_wr_valid_o); // R7
  AST_PAUSE_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !mem_wr_valid_o); // R7
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o && fast_mode_i && hit) |=> rd_resp_valid_o); // R5
  AST_HIT_NO_MEM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o && fast_mode_i && hit) |=> !mem_rd_valid_o); // R5
  AST_CAREFUL_AFTER_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && !$past(mem_rd_valid_o) && !fast_q) |-> ($past(count) == '0)); // R8
  AST_RD_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o))); // R4
  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_out_q |-> !rd_ready_o); // R10
  AST_RESP_FOLLOWS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_out_q && mem_rd_resp_valid_i) |=> rd_resp_valid_o); // R10
endmodule

bind wr_bypass_buf wbuf_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .fast_mode_i         (fast_mode_i),
  .wr_ready_o          (wr_ready_o),
  .rd_valid_i          (rd_valid_i),
  .rd_ready_o          (rd_ready_o),
  .rd_resp_valid_o     (rd_resp_valid_o),
  .mem_wr_valid_o      (mem_wr_valid_o),
  .mem_rd_valid_o      (mem_rd_valid_o),
  .mem_rd_ready_i      (mem_rd_ready_i),
  .mem_rd_addr_o       (mem_rd_addr_o),
  .mem_rd_resp_valid_i (mem_rd_resp_valid_i),
  .count               (count),
  .hit                 (hit),
  .fast_q              (fast_q)
);

// File: tb/wr_bypass_buf_tb.sv
`timescale 1ns/1ps
module wr_bypass_buf_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_mode_i = 1'b1;
  logic wr_valid_i = 1'b0, rd_valid_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic wr_ready_o, rd_ready_o, rd_resp_valid_o;
  logic [DW-1:0] rd_resp_data_o;
  logic mem_wr_valid_o, mem_rd_valid_o;
  logic mem_wr_ready_i = 1'b0, mem_rd_ready_i = 1'b0;
  logic [AW-1:0] mem_wr_addr_o, mem_rd_addr_o;
  logic [DW-1:0] mem_wr_data_o;
  logic mem_rd_resp_valid_i = 1'b0;
  logic [DW-1:0] mem_rd_resp_data_i = '0;

  always #10 clk_i = ~clk_i;

  wr_bypass_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [DW-1:0] refmem[64];
  logic [DW-1:0] mem[64];

  // stimulus requested for next step
  logic n_wr_v = 0, n_rd_v = 0, n_mw = 0, n_mr = 1, n_fast = 1;
  logic [AW-1:0] n_wr_a = '0, n_rd_a = '0;
  logic [DW-1:0] n_wr_d = '0;

  // read tracking
  bit rd_busy = 0, fast_l = 0, exp_hit = 0, mr_seen = 0, rd_out = 0, prev_mrv = 0;
  logic [DW-1:0] exp_d = '0, mrd_data = '0, last_resp = '0;
  logic [AW-1:0] ra_l = '0;
  int acc_cyc = 0, mresp_cyc = 0, mdelay = 0, overtake = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit exp_rdy, hitq;
    @(negedge clk_i);
    cyc++;
    // observe outputs settled after the last edge
    exp_rdy = (qa.size() < DEPTH) && !(rd_busy && !fast_l && !mr_seen && !mem_rd_valid_o);
    chk(wr_ready_o == exp_rdy, (qa.size() == DEPTH) ? "R3 full blocks write" : "R1 write ready",
        wr_ready_o, exp_rdy);
    chk(mem_wr_valid_o == (qa.size() > 0 && !rd_out && !mem_rd_valid_o), "R2/R7 drain valid",
        mem_wr_valid_o, (qa.size() > 0 && !rd_out && !mem_rd_valid_o));
    if (mem_rd_valid_o && !prev_mrv && rd_busy && !fast_l)
      chk(qa.size() == 0, "R8 read after empty", qa.size(), 0);
    if (rd_busy && mem_rd_valid_o)
      chk(mem_rd_addr_o == ra_l, "R4 read address", mem_rd_addr_o, ra_l);
    if (rd_resp_valid_o) begin
      if (!rd_busy) chk(1'b0, "R10 spurious response", 1, 0);
      else begin
        chk(rd_resp_data_o == exp_d, exp_hit ? "R5 forwarded data" : "R10 memory data",
            rd_resp_data_o, exp_d);
        chk(mr_seen == !exp_hit, "R9 path per latched mode", mr_seen, !exp_hit);
        if (exp_hit) chk(cyc == acc_cyc + 1, "R5 hit latency", cyc - acc_cyc, 1);
        else         chk(cyc == mresp_cyc + 1, "R10 response latency", cyc - mresp_cyc, 1);
      end
      last_resp = rd_resp_data_o;
      rd_busy = 0;
    end
    prev_mrv = mem_rd_valid_o;
    // drive inputs for the next edge
    wr_valid_i = n_wr_v; wr_addr_i = n_wr_a; wr_data_i = n_wr_d;
    rd_valid_i = n_rd_v && rd_ready_o && !rd_busy; rd_addr_i = n_rd_a;
    fast_mode_i = n_fast; mem_wr_ready_i = n_mw; mem_rd_ready_i = n_mr;
    mem_rd_resp_valid_i = 1'b0;
    if (rd_out) begin
      if (mdelay == 0) begin
        mem_rd_resp_valid_i = 1'b1; mem_rd_resp_data_i = mrd_data;
        rd_out = 0; mresp_cyc = cyc;
      end else mdelay--;
    end
    #1;
    // model the handshakes of the coming edge: write first, then read, then drain
    if (wr_valid_i && wr_ready_o) begin
      qa.push_back(wr_addr_i); qd.push_back(wr_data_i); refmem[wr_addr_i] = wr_data_i;
    end
    if (rd_valid_i) begin
      rd_busy = 1; fast_l = fast_mode_i; ra_l = rd_addr_i;
      exp_d = refmem[rd_addr_i]; hitq = 0;
      foreach (qa[i]) if (qa[i] == rd_addr_i) hitq = 1;
      exp_hit = fast_l && hitq; acc_cyc = cyc; mr_seen = 0;
    end
    if (mem_wr_valid_o && mem_wr_ready_i) begin
      if (qa.size() == 0) chk(1'b0, "R2 write from empty", 1, 0);
      else begin
        chk(mem_wr_addr_o == qa[0] && mem_wr_data_o == qd[0], "R2 drain order",
            {mem_wr_addr_o, mem_wr_data_o}, {qa[0], qd[0]});
        mem[mem_wr_addr_o] = mem_wr_data_o;
        void'(qa.pop_front()); void'(qd.pop_front());
      end
    end
    if (mem_rd_valid_o && mem_rd_ready_i) begin
      if (!rd_busy || exp_hit) chk(1'b0, "R5 unexpected memory read", 1, 0);
      if (fast_l && qa.size() > 0) overtake++;
      mr_seen = 1; rd_out = 1; mdelay = int'($urandom_range(2, 0));
      mrd_data = mem[mem_rd_addr_o];
    end
  endtask

  task automatic clr();
    n_wr_v = 0; n_rd_v = 0;
  endtask

  task automatic wait_resp();
    for (int i = 0; i < 200 && rd_busy; i++) step();
    chk(!rd_busy, "R10 read completes", rd_busy, 0);
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
    n_wr_v = 1; n_wr_a = a; n_wr_d = d; step(); clr();
  endtask

  task automatic get(input logic [AW-1:0] a);
    n_rd_v = 1; n_rd_a = a; step(); clr();
  endtask

  task automatic drain_all();
    n_mw = 1; n_mr = 1; clr();
    for (int i = 0; i < 400 && (rd_busy || qa.size() > 0); i++) step();
    chk(qa.size() == 0 && !rd_busy, "R2 queue empties", qa.size(), 0);
  endtask

  task automatic rand_phase(input int n, input int sel);
    for (int i = 0; i < n; i++) begin
      n_wr_v = ($urandom % 3) != 0;
      n_wr_a = AW'($urandom % 12);
      n_wr_d = DW'($urandom);
      n_rd_v = ($urandom % 4) == 0;
      n_rd_a = AW'($urandom % 12);
      n_mw   = ($urandom % 2) == 0;
      n_mr   = ($urandom % 3) != 0;
      n_fast = (sel == 2) ? 1'($urandom % 2) : 1'(sel);
      step();
    end
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin refmem[i] = '0; mem[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(wr_ready_o && rd_ready_o, "R11 ready in reset", {wr_ready_o, rd_ready_o}, 2'b11);
    chk(!mem_wr_valid_o && !mem_rd_valid_o && !rd_resp_valid_o, "R11 idle in reset",
        {mem_wr_valid_o, mem_rd_valid_o, rd_resp_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(wr_ready_o && rd_ready_o && !mem_wr_valid_o && !mem_rd_valid_o, "R11 after reset",
        {wr_ready_o, rd_ready_o, mem_wr_valid_o, mem_rd_valid_o}, 4'b1100);

    // fill with drain stalled, then offer one more (R3)
    n_fast = 1; n_mw = 0;
    put(6'd5, 16'h0111); put(6'd5, 16'h0222); put(6'd9, 16'h0333); put(6'd12, 16'h0444);
    put(6'd13, 16'h0555);
    chk(qa.size() == DEPTH, "R3 model holds DEPTH", qa.size(), DEPTH);
    // youngest duplicate forwarded (R5)
    get(6'd5); wait_resp();
    chk(last_resp == 16'h0222, "R5 youngest match", last_resp, 16'h0222);
    // miss overtakes queued writes (R4)
    n_mw = 1;
    begin
      int ov0 = overtake;
      get(6'd7); wait_resp();
      chk(overtake == ov0 + 1, "R4 read overtakes writes", overtake, ov0 + 1);
      chk(last_resp == 16'h0000, "R4 miss data", last_resp, 0);
    end
    drain_all();
    // same-cycle write and read (R6)
    n_mw = 0;
    n_wr_v = 1; n_wr_a = 6'd20; n_wr_d = 16'h0a55; n_rd_v = 1; n_rd_a = 6'd20; step(); clr();
    wait_resp();
    chk(last_resp == 16'h0a55, "R6 same-cycle write forwarded", last_resp, 16'h0a55);
    put(6'd21, 16'h0777);
    n_wr_v = 1; n_wr_a = 6'd21; n_wr_d = 16'h0888; n_rd_v = 1; n_rd_a = 6'd21; step(); clr();
    wait_resp();
    chk(last_resp == 16'h0888, "R6 incoming beats older entry", last_resp, 16'h0888);
    // careful mode waits for drain (R8)
    n_fast = 0;
    put(6'd30, 16'h0666);
    get(6'd30);
    n_fast = 1; // changes after acceptance must not matter (R9)
    for (int i = 0; i < 5; i++) step();
    chk(rd_busy && !mr_seen, "R8 read held while queue busy", {rd_busy, mr_seen}, 2'b10);
    n_mw = 1; wait_resp();
    chk(last_resp == 16'h0666, "R8 drained data returned", last_resp, 16'h0666);
    drain_all();

    rand_phase(3000, 1);
    drain_all();
    rand_phase(3000, 0);
    drain_all();
    rand_phase(4000, 2);
    drain_all();
    chk(overtake > 0, "R4 random overtakes seen", overtake, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule